// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This unit watches a bank of 28 general-purpose input pins and turns selected signal transitions into interrupt requests. Each pin can be armed to catch a low-to-high transition, a high-to-low transition, or both. When an armed transition arrives, the pin's sticky event bit is set. That bit holds until software clears it by writing a one to its position.

Every input passes through a two-stage synchroniser before anything looks at it. A transition is found by comparing the synchronised level with its value one clock earlier. Pins 0 to 10 each drive a dedicated level-sensitive interrupt line. The event bits of pins 11 to 27 are ORed into a single shared line. For a shared interrupt, software reads the event register to find out which upper pin caused it.

The register port is word-addressed and writes happen in a single cycle. Read data is combinational from the selected register. The unit has no internal sequencer: all of its state is the synchroniser pipeline, the two arming registers and the event register.

Top module: `gpio_edge_irq`

## Requirements
- R1: While reset is asserted and right after it, the rise-arm, fall-arm and event registers read 0 and every interrupt output is low.
- R2: The pin-level register (address 0) shows each pin's value as it was sampled two clock edges earlier (two-flop synchroniser).
- R3: A 0-to-1 transition of a synchronised pin whose bit is set in the rise-arm register (address 1) sets that pin's event bit on the next edge. This is the third clock edge after the pin changes.
- R4: A 1-to-0 transition of a synchronised pin whose bit is set in the fall-arm register (address 2) sets that pin's event bit with the same timing as R3.
- R5: A pin armed in both registers sets its event bit on either transition.
- R6: Writing to the event register (address 3) clears each bit written as 1. Bits written as 0 are left unchanged, and event bits stay set until they are cleared this way.
- R7: Clearing a pin's bit in both arming registers stops new transitions on that pin from being recorded. An event bit that is already set stays set.
- R8: If a transition is recorded on a bit in the same cycle that a write clears it, the bit ends up set.
- R9: irq_low[i] is high exactly while event bit i is set, for i = 0 to 10.
- R10: irq_high is high exactly while at least one of event bits 11 to 27 is set.
- R11: Register map: address 0 is pin level (read-only, writes have no effect), 1 is rise-arm, 2 is fall-arm, 3 is event status. Each register uses data bits 27:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 28 | Asynchronous pin inputs |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Word address for both read and write |
| reg_wdata | input | 28 | Write data |
| reg_rdata | output | 28 | Read data for the addressed register |
| irq_low | output | 11 | Dedicated interrupt lines for pins 0 to 10 |
| irq_high | output | 1 | Shared interrupt line for pins 11 to 27 |

## Verification
The bench goes after a clearing write that lands in the same cycle as a new transition. A design that let the clear win would lose that event without any trace. It also checks that writing zeros to the event register leaves it alone, that a write to the read-only level register changes nothing, and that disarming a pin leaves its old event bit set. A design that decoded write data as a plain store, or that masked events with the arming bits, would fail these checks. The bench also tracks the exact three-edge latency and keeps the shared line high while any upper pin is still pending. An off-by-one synchroniser, or an OR that misses the edge bits 11 and 27, would show up as a mismatch against the reference model on some cycle.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int unsigned DEF_PINS     = 28;
    localparam int unsigned DEF_LOW_PINS = 11;

    typedef enum logic [1:0] {
        SEL_LEVEL   = 2'd0,
        SEL_RISE_EN = 2'd1,
        SEL_FALL_EN = 2'd2,
        SEL_EVENT   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise_ev,
    output logic [W-1:0] fall_ev
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
            last   <= '0;
        end else begin
            stage1 <= pin_in;
            stage2 <= stage1;
            last   <= stage2;
        end
    end

    for (genvar i = 0; i < int'(W); i++) begin : g_edge
        assign rise_ev[i] =  stage2[i] & ~last[i];
        assign fall_ev[i] = ~stage2[i] &  last[i];
    end

    assign level = stage2;

    // warm-up counter so the latency check only looks at post-reset samples
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)               warm <= 2'd0;
        else if (warm != 2'd2)    warm <= warm + 2'd1;
    end

    p_sync_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> (level == $past(pin_in, 2)))
        else $error("R2: level does not match pins two edges back");
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] rise_ev,
    input  logic [W-1:0] fall_ev,
    output logic [W-1:0] rise_en,
    output logic [W-1:0] fall_en,
    output logic [W-1:0] status
);
    logic [W-1:0] hit;
    logic [W-1:0] clr;
    logic [W-1:0] keep;

    assign hit  = (rise_ev & rise_en) | (fall_ev & fall_en);
    assign clr  = (wr_en && wr_sel == SEL_EVENT) ? wr_data : '0;
    assign keep = status & ~clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            status  <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_RISE_EN) rise_en <= wr_data;
            if (wr_en && wr_sel == SEL_FALL_EN) fall_en <= wr_data;
            status <= keep | hit;
        end
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(keep)) == $past(keep)))
        else $error("R6: uncleared event bit dropped");

    p_disarmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(rise_en | fall_en)) == '0))
        else $error("R7: event recorded on a disarmed pin");

    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hit & clr)) |=> ((status & $past(hit & clr)) == $past(hit & clr)))
        else $error("R8: clear beat a simultaneous edge");
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
    parameter int unsigned W    = 28,
    parameter int unsigned NLOW = 11
) (
    input  logic [W-1:0]    status,
    output logic [NLOW-1:0] irq_low,
    output logic            irq_high
);
    localparam int unsigned NHIGH = W - NLOW;

    for (genvar i = 0; i < int'(NLOW); i++) begin : g_low
        assign irq_low[i] = status[i];
    end

    logic [NHIGH-1:0] upper;
    assign upper    = status[W-1:NLOW];
    assign irq_high = |upper;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int unsigned W    = DEF_PINS,
    parameter int unsigned NLOW = DEF_LOW_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    pin_in,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [W-1:0]    reg_wdata,
    output logic [W-1:0]    reg_rdata,
    output logic [NLOW-1:0] irq_low,
    output logic            irq_high
);
    reg_sel_e     sel;
    logic [W-1:0] level, rise_ev, fall_ev;
    logic [W-1:0] rise_en, fall_en, status;

    assign sel = reg_sel_e'(reg_addr);

    gpio_pin_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .level   (level),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    gpio_edge_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (sel),
        .wr_data (reg_wdata),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .status  (status)
    );

    gpio_irq_route #(.W(W), .NLOW(NLOW)) u_route (
        .status   (status),
        .irq_low  (irq_low),
        .irq_high (irq_high)
    );

    always_comb begin
        unique case (sel)
            SEL_LEVEL:   reg_rdata = level;
            SEL_RISE_EN: reg_rdata = rise_en;
            SEL_FALL_EN: reg_rdata = fall_en;
            SEL_EVENT:   reg_rdata = status;
            default:     reg_rdata = '0;
        endcase
    end

    p_low_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_EVENT) |-> (reg_rdata[NLOW-1:0] == irq_low))
        else $error("R9: dedicated line disagrees with event bit");

    p_shared_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_EVENT) |-> ((|reg_rdata[W-1:NLOW]) == irq_high))
        else $error("R10: shared line disagrees with upper event bits");
endmodule

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;
    localparam int W = 28;
    localparam logic [27:0] ALL = 28'hFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [27:0] reg_wdata = '0;
    logic [27:0] reg_rdata;
    logic [10:0] irq_low;
    logic        irq_high;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    gpio_edge_irq uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_low(irq_low), .irq_high(irq_high)
    );

    // behavioural reference model
    bit [27:0] m_q1, m_q2, m_old, m_ren, m_fen, m_ev;
    always @(posedge clk) begin
        bit [27:0] nxt;
        if (!rst_n) begin
            m_q1 = '0; m_q2 = '0; m_old = '0;
            m_ren = '0; m_fen = '0; m_ev = '0;
        end else begin
            nxt = m_ev;
            if (reg_wr && reg_addr == 2'd3) nxt = nxt & ~reg_wdata;
            for (int p = 0; p < W; p++) begin
                if (m_q2[p] && !m_old[p] && m_ren[p]) nxt[p] = 1'b1;
                if (!m_q2[p] && m_old[p] && m_fen[p]) nxt[p] = 1'b1;
            end
            if (reg_wr && reg_addr == 2'd1) m_ren = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_fen = reg_wdata;
            m_ev  = nxt;
            m_old = m_q2;
            m_q2  = m_q1;
            m_q1  = pin_in;
        end
    end

    function automatic logic [27:0] model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_q2;
            2'd1: return m_ren;
            2'd2: return m_fen;
            default: return m_ev;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            #2;
            chk(reg_rdata == model_read(reg_addr), "R11 model readback", {4'h0, reg_rdata}, {4'h0, model_read(reg_addr)});
            chk(irq_low == m_ev[10:0], "R9 model dedicated lines", {21'h0, irq_low}, {21'h0, m_ev[10:0]});
            chk(irq_high == (|m_ev[27:11]), "R10 model shared line", {31'h0, irq_high}, {31'h0, |m_ev[27:11]});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [27:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [27:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [27:0] v;
        pin_in = 28'h5A5_A5A5;
        tick(3);
        #2;
        chk(irq_low == '0 && irq_high == 1'b0, "R1 irq low in reset", {20'h0, irq_low, irq_high}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd1, v); chk(v == '0, "R1 rise-arm reset", {4'h0, v}, 32'h0);
        rd(2'd2, v); chk(v == '0, "R1 fall-arm reset", {4'h0, v}, 32'h0);
        rd(2'd3, v); chk(v == '0, "R1 event reset", {4'h0, v}, 32'h0);
        cmp_on = 1;
        pin_in = '0;
        tick(4);
        wr(2'd3, ALL);

        // R3/R5 setup: bit0 rise, bit1 fall, bit15 both, bit2 none
        wr(2'd1, 28'h0008001);
        wr(2'd2, 28'h0008002);
        pin_in = 28'h0008007;
        tick(2);
        rd(2'd0, v); chk(v == 28'h0008007, "R2 level after two edges", {4'h0, v}, 32'h0008007);
        tick(2);
        rd(2'd3, v); chk(v == 28'h0008001, "R3 rising events", {4'h0, v}, 32'h0008001);
        chk(irq_low == 11'h001, "R9 dedicated line pin0", {21'h0, irq_low}, 32'h1);
        chk(irq_high == 1'b1, "R10 shared line pin15", {31'h0, irq_high}, 32'h1);

        pin_in = '0;
        tick(4);
        rd(2'd3, v); chk(v == 28'h0008003, "R4 R5 falling events", {4'h0, v}, 32'h0008003);

        wr(2'd3, 28'h0000001);
        rd(2'd3, v); chk(v == 28'h0008002, "R6 write-one clears", {4'h0, v}, 32'h0008002);
        wr(2'd3, 28'h0000000);
        rd(2'd3, v); chk(v == 28'h0008002, "R6 write-zero no effect", {4'h0, v}, 32'h0008002);
        wr(2'd3, 28'h0008000);
        #1; chk(irq_high == 1'b0, "R10 shared line drops", {31'h0, irq_high}, 32'h0);

        // R7: disarm everything; old bit1 stays
        wr(2'd1, '0);
        wr(2'd2, '0);
        pin_in = 28'h8000802;
        tick(4);
        pin_in = '0;
        tick(4);
        rd(2'd3, v); chk(v == 28'h0000002, "R7 disarmed pin records nothing", {4'h0, v}, 32'h2);

        // R11: write to level register ignored
        pin_in = 28'h0000010;
        tick(3);
        wr(2'd0, ALL);
        rd(2'd0, v); chk(v == 28'h0000010, "R11 level register read-only", {4'h0, v}, 32'h10);
        rd(2'd1, v); chk(v == '0, "R11 write to address 0 leaves arming", {4'h0, v}, 32'h0);
        pin_in = '0;
        tick(4);

        // R8: clearing write coincides with the recording edge
        wr(2'd3, ALL);
        wr(2'd1, 28'h0000008);
        pin_in = 28'h0000008;
        tick(2);
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 28'h0000008;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
        rd(2'd3, v); chk(v == 28'h0000008, "R8 edge beats clear", {4'h0, v}, 32'h8);
        wr(2'd3, ALL);
        rd(2'd3, v); chk(v == '0, "R6 clear all", {4'h0, v}, 32'h0);

        // boundary pins 10, 11, 27 armed on both edges
        wr(2'd1, 28'h8000C00);
        wr(2'd2, 28'h8000C00);
        pin_in = 28'h8000000;
        tick(4);
        chk(irq_high == 1'b1 && irq_low == '0, "R10 pin27 shared only", {20'h0, irq_low, irq_high}, 32'h1);
        pin_in = 28'h8000400;
        tick(4);
        chk(irq_low == 11'h400, "R9 pin10 dedicated", {21'h0, irq_low}, 32'h400);

        // randomised phase against the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            pin_in = pin_in ^ ($urandom & $urandom & $urandom & 28'hFFF_FFFF);
            reg_wr = (($urandom % 4) == 0);
            reg_addr = 2'($urandom % 4);
            reg_wdata = 28'($urandom);
        end
        @(negedge clk);
        reg_wr = 1'b0;
        tick(2);
        finish_run();
    end
endmodule